// File: doc/BRIEF.md
# Write-Combining Store Queue Burst Flusher

This block holds two small write-combining queues of eight 32-bit longwords each, sixteen entries in all. The processor fills them with single longword writes, indexed by the word address, and can read any entry back at once. A flush command names a 32-byte line. Line-address bit 5 picks one queue. The block then sends that queue's eight longwords as one burst of eight beats on a valid/ready output, all at a single 32-byte-aligned target address.

The target address comes from one of two sources. When translation is off, the line address supplies target bits [25:5]. The selected queue's 8-bit area register is placed at bits [31:24] and ORed in. The two area registers are written through a plain register port. When translation is on, the supplied line address is used as it is, limited to bits [28:5].

Back-pressure rules: a write completes on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while a burst runs and in any cycle where `flush_valid` is high, so a flush always wins over a write in the same cycle. A burst beat completes on a cycle where `bst_valid` and `bst_ready` are both high. While `bst_ready` is low, the beat's address, data and last flag are held.

Top module: `sq_burst_flusher`

## Requirements
- R1: A completed write stores `wr_data` in entry `wr_word` (address bits [5:2]). `rd_data` shows entry `rd_word` combinationally, and all entries read zero after reset.
- R2: Line bit 0 (address bit 5) picks the queue: 0 gives entries 0..7 and 1 gives entries 8..15. Beats carry those entries in ascending order.
- R3: With `flush_xlat`=0, the target is `{area,24'b0} | {6'b0, flush_line[20:0], 5'b0}`. `area` is the selected queue's area register: register 0 for queue 0 and register 1 for queue 1.
- R4: With `flush_xlat`=1, the target is `{3'b0, flush_line, 5'b0}`, which is the address masked to 0x1FFFFFE0.
- R5: Every flush yields exactly eight beats. `bst_last` is high only on the eighth beat, and `bst_addr` is the same 32-byte-aligned target on every beat.
- R6: A flush is accepted only when `flush_busy` is low. `flush_busy` is high from the cycle after acceptance until the last beat completes, and a request seen while busy starts no burst.
- R7: `wr_ready` is low while `flush_busy` or `flush_valid` is high, and no write reaches the storage in those cycles.
- R8: Both area registers reset to zero and are written through `cfg_we`/`cfg_sel`. The target uses the register value from the accepting cycle, before any register write in that same cycle.
- R9: While `bst_valid` is high and `bst_ready` is low, `bst_valid`, `bst_addr`, `bst_data` and `bst_last` hold their values.
- R10: After reset, `flush_busy` and `bst_valid` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Longword write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_word | input | 4 | Entry index (address bits [5:2]) |
| wr_data | input | 32 | Write data |
| rd_word | input | 4 | Read-back entry index |
| rd_data | output | 32 | Read-back data |
| cfg_we | input | 1 | Area register write strobe |
| cfg_sel | input | 1 | Area register select |
| cfg_wdata | input | 8 | Area register value |
| flush_valid | input | 1 | Flush request |
| flush_line | input | 24 | Line address (address bits [28:5]) |
| flush_xlat | input | 1 | 1: translated, use line address directly |
| flush_busy | output | 1 | Burst in progress |
| bst_valid | output | 1 | Burst beat valid |
| bst_ready | input | 1 | Burst sink ready |
| bst_addr | output | 32 | Burst target address |
| bst_data | output | 32 | Burst beat data |
| bst_last | output | 1 | Final beat of the burst |

## Verification
Three things can fall in the same cycle and compete with a flush request: a processor write, an area-register write, and a second flush request that arrives while a burst is still running. The bench raises a write and a flush on the same edge. It expects the write to stall, the burst to carry the old data, and the new data to appear on read-back afterwards. It also writes an area register on the accepting edge and expects the old area value in the target. Finally, it pulses a flush mid-burst, and the scoreboard flags any beat it did not expect.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int DATA_W  = 32;
  localparam int QWORDS  = 8;
  localparam int NQUEUES = 2;
  localparam int AREA_W  = 8;
  localparam int LINE_W  = 24;
  localparam int ENTRIES = NQUEUES * QWORDS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int BEAT_W  = $clog2(QWORDS);
  localparam int QSEL_W  = $clog2(NQUEUES);
  localparam int UNXL_W  = 21;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/sqf_store.sv
module sqf_store
  import sqf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  word_t            w_data,
  input  logic [IDX_W-1:0] cpu_idx,
  output word_t            cpu_data,
  input  logic             burst_act,
  input  logic [IDX_W-1:0] bst_idx,
  output word_t            bst_data
);
  word_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[w_idx] <= w_data;
    end
  end

  assign cpu_data = mem[cpu_idx];
  assign bst_data = mem[bst_idx];

  // R7: storage never written while a burst reads it
  p_no_write_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act |-> !we);
endmodule

// File: rtl/sqf_target.sv
module sqf_target
  import sqf_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic              xlat,
  input  logic [AREA_W-1:0] area,
  output logic [31:0]       target
);
  localparam int HI_PAD = 32 - LINE_W - 5;
  localparam int UN_PAD = 32 - UNXL_W - 5;

  always_comb begin
    if (xlat) target = {{HI_PAD{1'b0}}, line, 5'b0};
    else      target = {area, {(32-AREA_W){1'b0}}} |
                       {{UN_PAD{1'b0}}, line[UNXL_W-1:0], 5'b0};
  end
endmodule

// File: rtl/sqf_sequencer.sv
module sqf_sequencer
  import sqf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [QSEL_W-1:0] req_q,
  input  logic [31:0]      req_target,
  output logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  output logic             bst_valid,
  input  logic             bst_ready,
  output logic [31:0]      bst_addr,
  output logic             bst_last
);
  logic [BEAT_W-1:0] beat;
  logic [QSEL_W-1:0] qsel;
  logic [31:0]       tgt;
  logic              accept;
  logic              final_beat;

  assign accept     = req && !busy;
  assign final_beat = (beat == BEAT_W'(QWORDS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
      qsel <= '0;
      tgt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      beat <= '0;
      qsel <= req_q;
      tgt  <= req_target;
    end else if (busy && bst_ready) begin
      if (final_beat) busy <= 1'b0;
      else            beat <= beat + 1'b1;
    end
  end

  assign rd_idx    = {qsel, beat};
  assign bst_valid = busy;
  assign bst_addr  = tgt;
  assign bst_last  = busy && final_beat;

  // R9: a stalled beat holds
  p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(rd_idx) && $stable(bst_last)));
  // R5: the burst ends right after its last beat
  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_last && bst_ready) |=> !bst_valid);
  // R6: a burst starts only from a request
  p_start_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
endmodule

// File: rtl/sq_burst_flusher.sv
module sq_burst_flusher
  import sqf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [IDX_W-1:0]    wr_word,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_word,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [AREA_W-1:0]   cfg_wdata,
  input  logic                flush_valid,
  input  logic [LINE_W-1:0]   flush_line,
  input  logic                flush_xlat,
  output logic                flush_busy,
  output logic                bst_valid,
  input  logic                bst_ready,
  output logic [31:0]         bst_addr,
  output logic [DATA_W-1:0]   bst_data,
  output logic                bst_last
);
  logic [AREA_W-1:0] area_q [NQUEUES];
  logic [IDX_W-1:0]  seq_idx;
  logic [31:0]       target;
  logic [QSEL_W-1:0] req_q;
  logic              wr_en;

  assign req_q    = flush_line[QSEL_W-1:0];
  assign wr_ready = !flush_busy && !flush_valid;
  assign wr_en    = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQUEUES; i++) area_q[i] <= '0;
    end else if (cfg_we) begin
      area_q[cfg_sel] <= cfg_wdata;
    end
  end

  sqf_store u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .w_idx(wr_word), .w_data(wr_data),
    .cpu_idx(rd_word), .cpu_data(rd_data),
    .burst_act(flush_busy), .bst_idx(seq_idx), .bst_data(bst_data)
  );

  sqf_target u_target (
    .line(flush_line), .xlat(flush_xlat), .area(area_q[req_q]), .target(target)
  );

  sqf_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req(flush_valid), .req_q(req_q),
    .req_target(target), .busy(flush_busy), .rd_idx(seq_idx),
    .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
    .bst_last(bst_last)
  );

  // R5: every beat targets a 32-byte-aligned address
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_addr[4:0] == 5'd0));
endmodule

// File: tb/sq_burst_flusher_bench.sv
`timescale 1ns/1ps
module sq_burst_flusher_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic wr_valid = 0, wr_ready;
  logic [3:0] wr_word = 0, rd_word = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic flush_valid = 0, flush_xlat = 0, flush_busy;
  logic [23:0] flush_line = 0;
  logic bst_valid, bst_ready = 0, bst_last;
  logic [31:0] bst_addr, bst_data;

  sq_burst_flusher u_sq_burst_flusher (.*);

  int checks = 0, failures = 0;
  logic [31:0] model [16];
  logic [7:0]  area_m [2];
  logic [64:0] sb [$];
  int rdy_cnt = 0;
  logic hold_v = 0;
  logic [32:0] hold_d;
  logic [31:0] hold_a;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] tgt_of(logic [23:0] line, logic xl);
    if (xl) return {3'b0, line, 5'b0};
    return {area_m[line[0]], 24'b0} | {6'b0, line[20:0], 5'b0};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    bst_ready = ((rdy_cnt % 5) != 2) && ((rdy_cnt % 7) != 4);
    rdy_cnt++;
    #1;
    if (hold_v) begin
      chk(bst_valid && bst_addr == hold_a && {bst_last, bst_data} == hold_d,
          "R9 stalled beat held", {bst_last, bst_data}, hold_d);
    end
    hold_v = bst_valid && !bst_ready;
    hold_a = bst_addr; hold_d = {bst_last, bst_data};
    if (bst_valid && bst_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R6 unexpected beat", {32'b0, bst_addr}, 64'b0);
      end else begin
        logic [64:0] e;
        e = sb.pop_front();
        chk(bst_addr == e[63:32], "R3/R4 beat address", bst_addr, e[63:32]);
        chk(bst_data == e[31:0], "R2 beat data", bst_data, e[31:0]);
        chk(bst_last == e[64], "R5 last flag", bst_last, e[64]);
      end
    end
  end

  task automatic do_write(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_word = w; wr_data = d;
    #2;
    while (!wr_ready) begin @(negedge clk); #2; end
    @(posedge clk); model[w] = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic do_cfg(input logic s, input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(posedge clk); area_m[s] = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push_exp(input logic [23:0] line, input logic xl);
    logic [31:0] t;
    t = tgt_of(line, xl);
    for (int b = 0; b < 8; b++) sb.push_back({(b == 7), t, model[{line[0], 3'(b)}]});
  endtask

  // issues a flush; returns right after the accepting edge
  task automatic do_flush(input logic [23:0] line, input logic xl);
    @(negedge clk);
    while (flush_busy) @(negedge clk);
    flush_valid = 1; flush_line = line; flush_xlat = xl;
    push_exp(line, xl);
    @(negedge clk); flush_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((flush_busy || sb.size() != 0) && n < 400) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0 && !flush_busy, "R5 all eight beats delivered", sb.size(), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    area_m[0] = 0; area_m[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!flush_busy && !bst_valid, "R10 idle after reset", {flush_busy, bst_valid}, 0);
    chk(wr_ready, "R10 write ready after reset", wr_ready, 1);
    rd_word = 4'd9; #1;
    chk(rd_data == 0, "R1 storage zero after reset", rd_data, 0);

    for (int i = 0; i < 16; i++) do_write(4'(i), 32'hA500_0000 + 32'(i * 32'h1111));
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk); rd_word = 4'(i); #1;
      chk(rd_data == model[i], "R1 read-back", rd_data, model[i]);
    end

    // R8: area registers reset to zero -> untranslated target has zero high byte
    do_flush(24'h00_1234, 1'b0); wait_idle();
    do_cfg(1'b0, 8'hC3); do_cfg(1'b1, 8'h5A);
    do_flush(24'hF7_8A42, 1'b0); wait_idle();   // R3 queue 0
    do_flush(24'h3F_FFFF, 1'b0); wait_idle();   // R3 queue 1, overlap bits
    do_flush(24'hAB_CDE1, 1'b1); wait_idle();   // R4 queue 1
    do_flush(24'hFF_FFFE, 1'b1); wait_idle();   // R4 queue 0

    // R7: write and flush in the same cycle: flush wins, write waits
    @(negedge clk);
    wr_valid = 1; wr_word = 4'd3; wr_data = 32'hDEAD_0003;
    flush_valid = 1; flush_line = 24'h00_0040; flush_xlat = 0;
    push_exp(24'h00_0040, 1'b0);
    #1; chk(!wr_ready, "R7 write stalled by flush request", wr_ready, 0);
    @(negedge clk); flush_valid = 0; #1;
    chk(!wr_ready && flush_busy, "R7 write stalled during burst", {wr_ready, flush_busy}, 1);
    rd_word = 4'd3; #1;
    chk(rd_data == model[3], "R7 no write during burst", rd_data, model[3]);
    #1;
    while (!wr_ready) begin @(negedge clk); #2; end
    @(posedge clk); model[3] = 32'hDEAD_0003;
    @(negedge clk); wr_valid = 0;
    wait_idle();
    rd_word = 4'd3; #1;
    chk(rd_data == 32'hDEAD_0003, "R7 stalled write lands after burst", rd_data, 32'hDEAD_0003);

    // R8: area write in the accepting cycle -> old value used
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 8'h77;
    flush_valid = 1; flush_line = 24'h00_0021; flush_xlat = 0;
    push_exp(24'h00_0021, 1'b0);
    @(posedge clk); area_m[1] = 8'h77;
    @(negedge clk); cfg_we = 0; flush_valid = 0;
    wait_idle();
    do_flush(24'h00_0021, 1'b0); wait_idle();   // R8 new value now used

    // R6: request pulse mid-burst is ignored
    do_flush(24'h12_3450, 1'b0);
    @(negedge clk);
    flush_valid = 1; flush_line = 24'h00_0001; flush_xlat = 1;
    #1; chk(flush_busy, "R6 busy during burst", flush_busy, 1);
    @(negedge clk); flush_valid = 0;
    wait_idle();
    repeat (12) @(negedge clk);
    chk(!bst_valid && !flush_busy, "R6 no second burst", {bst_valid, flush_busy}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule